// File: doc/BRIEF.md
# Smart Card Character Transmitter with Error-Signal Retry

This block sends one character at a time to a smart card over a shared open-drain I/O line. It uses the character-level error handling of the T=0 protocol. A character is framed as a start bit, eight data bits with the least significant bit first, and an even parity bit. Each bit lasts one elementary time unit (ETU). The ETU timing comes from outside the block as a single-cycle `etu_tick` strobe. The block never drives the line high. It either pulls the line low or leaves it released.

After the parity bit the block releases the line and listens to the line itself for one more ETU. If the card pulls the line low in that slot, the card has rejected the character. The block then:
- sets a sticky error flag,
- can raise an error interrupt,
- waits out a two-ETU guard interval,
- sends the same character again.

The transmission-end flag is set only when a frame goes through with no error signal. An optional limit stops the block after a fixed number of rejected attempts. When the limit is hit, the block flags the abort and keeps the error flag pinned until the next character is started.

Top module: `sc_char_tx`

## Requirements
- R1: After reset the line is released (`io_drive_low`=0) and `busy`, `err_flag`, `tend_flag`, `abort_flag`, `err_irq` and `tend_irq` are all 0.
- R2: A `tx_start` pulse while idle latches `tx_data` and pulls the line low (the start bit) on the next clock. Each following `etu_tick` drives the next bit: D0 first through D7, then a parity bit equal to the XOR of the data bits (even parity). A 0 bit pulls the line low (`io_drive_low`=1) and a 1 bit releases it.
- R3: On the `etu_tick` that ends the parity bit, the line is released. It stays released through the error slot and the guard interval, and whenever the block is idle.
- R4: On the next `etu_tick` after the line is released, the block samples `io_in`. A low level sets `err_flag` and leaves `tend_flag` clear.
- R5: `err_irq` equals `err_flag` AND `err_ie`, and `tend_irq` equals `tend_flag` AND `tend_ie`. Both are registered and update in the same cycle as their flags.
- R6: After an error slot, the line stays released for two ETU ticks. On the second tick, the start bit of a repeat frame carrying the same character is driven.
- R7: A high level in the error slot sets `tend_flag`, leaves `err_flag` unchanged and returns the block to idle (`busy`=0). `tend_flag` is cleared when a new character is accepted.
- R8: `err_flag` stays set until an `err_clr` pulse clears it.
- R9: With `lim_en`=1, the fourth rejected attempt of a character ends the transfer. The block goes idle without setting `tend_flag`, sets `abort_flag`, and ignores `err_clr` until the next `tx_start`.
- R10: With `lim_en`=0 there is no attempt limit, and a character rejected more than four times is still repeated until it is accepted.
- R11: A `tx_start` pulse while `busy` is 1 is ignored, and the frame in progress keeps its original data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| etu_tick | input | 1 | One-cycle strobe marking each ETU boundary |
| tx_start | input | 1 | Start sending `tx_data` (honoured only when idle) |
| tx_data | input | 8 | Character to send |
| lim_en | input | 1 | Enable the attempt limit |
| err_ie | input | 1 | Error interrupt enable |
| tend_ie | input | 1 | Transmission-end interrupt enable |
| err_clr | input | 1 | Clear pulse for the error flag |
| io_in | input | 1 | Sensed level of the shared I/O line |
| io_drive_low | output | 1 | 1 pulls the line low, 0 releases it |
| busy | output | 1 | A character is in progress |
| err_flag | output | 1 | Error signal received (sticky) |
| tend_flag | output | 1 | Character accepted |
| abort_flag | output | 1 | Attempt limit reached |
| err_irq | output | 1 | Error interrupt request |
| tend_irq | output | 1 | Transmission-end interrupt request |

## Verification
The characters are chosen to tell bit order and parity apart:
- all ones,
- all zeros,
- alternating patterns,
- single-bit-set values.

A swapped bit order or an odd parity shows up as a wrong line level in a specific ETU. These characters are sent with zero to six error signals in a row, with the limit both on and off. This separates accept-on-first-try, several repeats, an abort exactly at the fourth rejection, and unlimited repeating. It also confirms that every repeat frame carries the original bits. Directed runs cover interrupt masking and a second start request arriving in the middle of a frame.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_SLOT  = 2'd2,
    ST_GUARD = 2'd3
  } sc_state_e;
endpackage

// File: rtl/sc_tx_shifter.sv
module sc_tx_shifter #(
  parameter int DW = 8,
  localparam int IW = $clog2(DW + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] data_in,
  input  logic [IW-1:0] sel,
  output logic          bit_val
);
  logic [DW-1:0] data_q;
  logic          par;

  always_ff @(posedge clk) begin
    if (rst)       data_q <= '0;
    else if (load) data_q <= data_in;
  end

  assign par = ^data_q;

  // frame position 0 = start, 1..DW = data LSB first, DW+1 = parity
  always_comb begin
    bit_val = par;
    if (sel == '0) bit_val = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (sel == IW'(i + 1)) bit_val = data_q[i];
    end
  end
endmodule

// File: rtl/sc_tx_ctrl.sv
module sc_tx_ctrl
  import sc_tx_pkg::*;
#(
  parameter int DW        = 8,
  parameter int GUARD_ETU = 2,
  parameter int MAX_TRIES = 4,
  localparam int IW = $clog2(DW + 2),
  localparam int GW = $clog2(GUARD_ETU + 1),
  localparam int TW = $clog2(MAX_TRIES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          etu_tick,
  input  logic          tx_start,
  input  logic          lim_en,
  input  logic          io_in,
  input  logic          next_bit,
  output logic [IW-1:0] next_sel,
  output sc_state_e     state,
  output logic          drive_low,
  output logic          start_acc,
  output logic          ev_err,
  output logic          ev_ok,
  output logic          ev_abort
);
  localparam logic [IW-1:0] LAST = IW'(DW + 1);

  sc_state_e     state_q;
  logic [IW-1:0] idx_q;
  logic [GW-1:0] gcnt_q;
  logic [TW-1:0] tries_q;
  logic          drv_q;
  logic          slot_hit;

  assign start_acc = (state_q == ST_IDLE) && tx_start;
  assign slot_hit  = (state_q == ST_SLOT) && etu_tick;
  assign ev_err    = slot_hit && !io_in;
  assign ev_ok     = slot_hit && io_in;
  assign ev_abort  = ev_err && lim_en && (tries_q == TW'(MAX_TRIES - 1));
  assign next_sel  = idx_q + IW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      gcnt_q  <= '0;
      tries_q <= '0;
      drv_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          drv_q <= 1'b0;
          if (tx_start) begin
            state_q <= ST_SEND;
            idx_q   <= '0;
            tries_q <= '0;
            drv_q   <= 1'b1;
          end
        end
        ST_SEND: begin
          if (etu_tick) begin
            if (idx_q == LAST) begin
              state_q <= ST_SLOT;
              drv_q   <= 1'b0;
            end else begin
              idx_q <= next_sel;
              drv_q <= ~next_bit;
            end
          end
        end
        ST_SLOT: begin
          if (etu_tick) begin
            if (ev_abort || ev_ok) begin
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_GUARD;
              gcnt_q  <= '0;
              if (tries_q != TW'(MAX_TRIES)) tries_q <= tries_q + TW'(1);
            end
          end
        end
        default: begin
          if (etu_tick) begin
            if (gcnt_q == GW'(GUARD_ETU - 1)) begin
              state_q <= ST_SEND;
              idx_q   <= '0;
              drv_q   <= 1'b1;
            end else begin
              gcnt_q <= gcnt_q + GW'(1);
            end
          end
        end
      endcase
    end
  end

  assign state     = state_q;
  assign drive_low = drv_q;
endmodule

// File: rtl/sc_tx_status.sv
module sc_tx_status (
  input  logic clk,
  input  logic rst,
  input  logic start_acc,
  input  logic ev_err,
  input  logic ev_ok,
  input  logic ev_abort,
  input  logic err_clr,
  input  logic err_ie,
  input  logic tend_ie,
  output logic err_flag,
  output logic tend_flag,
  output logic abort_flag,
  output logic err_irq,
  output logic tend_irq
);
  logic err_d, tend_d, abort_d;

  always_comb begin
    err_d = err_flag;
    if (err_clr && !abort_flag) err_d = 1'b0;
    if (ev_err) err_d = 1'b1;
    tend_d = tend_flag;
    if (start_acc) tend_d = 1'b0;
    if (ev_ok) tend_d = 1'b1;
    abort_d = abort_flag;
    if (start_acc) abort_d = 1'b0;
    if (ev_abort) abort_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag   <= 1'b0;
      tend_flag  <= 1'b0;
      abort_flag <= 1'b0;
      err_irq    <= 1'b0;
      tend_irq   <= 1'b0;
    end else begin
      err_flag   <= err_d;
      tend_flag  <= tend_d;
      abort_flag <= abort_d;
      err_irq    <= err_d & err_ie;
      tend_irq   <= tend_d & tend_ie;
    end
  end
endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx
  import sc_tx_pkg::*;
#(
  parameter int DW        = 8,
  parameter int GUARD_ETU = 2,
  parameter int MAX_TRIES = 4,
  localparam int IW = $clog2(DW + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          etu_tick,
  input  logic          tx_start,
  input  logic [DW-1:0] tx_data,
  input  logic          lim_en,
  input  logic          err_ie,
  input  logic          tend_ie,
  input  logic          err_clr,
  input  logic          io_in,
  output logic          io_drive_low,
  output logic          busy,
  output logic          err_flag,
  output logic          tend_flag,
  output logic          abort_flag,
  output logic          err_irq,
  output logic          tend_irq
);
  sc_state_e     st;
  logic [IW-1:0] sel;
  logic          nbit, start_acc, ev_err, ev_ok, ev_abort;

  sc_tx_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .load(start_acc), .data_in(tx_data),
    .sel(sel), .bit_val(nbit)
  );

  sc_tx_ctrl #(.DW(DW), .GUARD_ETU(GUARD_ETU), .MAX_TRIES(MAX_TRIES)) u_ctrl (
    .clk(clk), .rst(rst), .etu_tick(etu_tick), .tx_start(tx_start),
    .lim_en(lim_en), .io_in(io_in), .next_bit(nbit), .next_sel(sel),
    .state(st), .drive_low(io_drive_low), .start_acc(start_acc),
    .ev_err(ev_err), .ev_ok(ev_ok), .ev_abort(ev_abort)
  );

  sc_tx_status u_stat (
    .clk(clk), .rst(rst), .start_acc(start_acc), .ev_err(ev_err),
    .ev_ok(ev_ok), .ev_abort(ev_abort), .err_clr(err_clr),
    .err_ie(err_ie), .tend_ie(tend_ie), .err_flag(err_flag),
    .tend_flag(tend_flag), .abort_flag(abort_flag),
    .err_irq(err_irq), .tend_irq(tend_irq)
  );

  assign busy = (st != ST_IDLE);
endmodule

// File: rtl/sc_char_tx_chk.sv
module sc_char_tx_chk
  import sc_tx_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      etu_tick,
  input logic      io_in,
  input logic      err_clr,
  input logic      io_drive_low,
  input logic      busy,
  input logic      err_flag,
  input logic      tend_flag,
  input logic      abort_flag,
  input logic      err_irq,
  input logic      tend_irq,
  input sc_state_e st
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !io_drive_low); // R3
  AST_SLOT_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SLOT || st == ST_GUARD) |-> !io_drive_low); // R3
  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> io_drive_low); // R2
  AST_ERR_NO_TEND: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SLOT && etu_tick && !io_in) |=> (err_flag && !tend_flag)); // R4
  AST_OK_TEND: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SLOT && etu_tick && io_in) |=> (tend_flag && !busy)); // R7
  AST_ERR_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> err_flag); // R5
  AST_TEND_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    tend_irq |-> tend_flag); // R5
  AST_ABORT_HOLDS_ERR: assert property (@(posedge clk) disable iff (rst)
    (abort_flag && err_clr) |=> err_flag); // R9
  AST_ABORT_IMPLIES_ERR: assert property (@(posedge clk) disable iff (rst)
    abort_flag |-> (err_flag && !tend_flag)); // R9
endmodule

bind sc_char_tx sc_char_tx_chk u_chk (
  .clk(clk), .rst(rst), .etu_tick(etu_tick), .io_in(io_in), .err_clr(err_clr),
  .io_drive_low(io_drive_low), .busy(busy), .err_flag(err_flag),
  .tend_flag(tend_flag), .abort_flag(abort_flag), .err_irq(err_irq),
  .tend_irq(tend_irq), .st(st)
);

// File: tb/sim_sc_char_tx.sv
module sim_sc_char_tx;
  localparam int MAXT = 4;
  // {data[15:8], error signals before acceptance[7:4], lim_en[3], pad}
  localparam int NV = 7;
  localparam logic [15:0] VEC [NV] = '{
    {8'hA5, 4'd0, 1'b1, 3'd0},
    {8'h3C, 4'd1, 1'b1, 3'd0},
    {8'hFF, 4'd2, 1'b0, 3'd0},
    {8'h00, 4'd3, 1'b1, 3'd0},
    {8'h81, 4'd4, 1'b1, 3'd0},
    {8'h5A, 4'd6, 1'b0, 3'd0},
    {8'h01, 4'd5, 1'b1, 3'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic etu_tick = 1'b0, tx_start = 1'b0, lim_en = 1'b0;
  logic err_ie = 1'b1, tend_ie = 1'b1, err_clr = 1'b0, card_pull = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic io_in, io_drive_low, busy, err_flag, tend_flag, abort_flag, err_irq, tend_irq;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  assign io_in = ~(io_drive_low | card_pull);

  sc_char_tx u0 (
    .clk(clk), .rst(rst), .etu_tick(etu_tick), .tx_start(tx_start),
    .tx_data(tx_data), .lim_en(lim_en), .err_ie(err_ie), .tend_ie(tend_ie),
    .err_clr(err_clr), .io_in(io_in), .io_drive_low(io_drive_low),
    .busy(busy), .err_flag(err_flag), .tend_flag(tend_flag),
    .abort_flag(abort_flag), .err_irq(err_irq), .tend_irq(tend_irq)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) etu_tick = 1'b1;
    @(negedge clk) etu_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
  endtask

  task automatic run_char(input logic [7:0] d, input int nerr, input logic lim, input logic intrude);
    int  att;
    logic ab;
    logic exp_b;
    ab  = lim && (nerr >= MAXT);
    att = ab ? MAXT : nerr + 1;
    lim_en = lim;
    @(negedge clk) begin tx_start = 1'b1; tx_data = d; end
    @(negedge clk) begin tx_start = 1'b0; tx_data = ~d; end
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(tend_flag == 1'b0, "R7 tend cleared on start", tend_flag, 0);
    pulse_clr();
    for (int a = 0; a < att; a++) begin
      chk(io_drive_low == 1'b1, "R2/R6 start bit", io_drive_low, 1);
      for (int k = 0; k < 9; k++) begin
        if (intrude && k == 3) begin
          @(negedge clk) tx_start = 1'b1;
          @(negedge clk) tx_start = 1'b0;
        end
        tick();
        exp_b = (k < 8) ? ~d[k] : ~(^d);
        chk(io_drive_low == exp_b, intrude ? "R11 frame kept" : "R2 bit level", io_drive_low, exp_b);
      end
      tick();
      chk(io_drive_low == 1'b0, "R3 released after parity", io_drive_low, 0);
      card_pull = (a < nerr);
      tick();
      card_pull = 1'b0;
      if (a < nerr) begin
        chk(err_flag == 1'b1, "R4 err set", err_flag, 1);
        chk(tend_flag == 1'b0, "R4 tend clear", tend_flag, 0);
        chk(err_irq == err_ie, "R5 err_irq", err_irq, err_ie);
        if (ab && a == att - 1) begin
          chk(busy == 1'b0, "R9 stopped", busy, 0);
          chk(abort_flag == 1'b1, "R9 abort", abort_flag, 1);
          pulse_clr();
          chk(err_flag == 1'b1, "R9 err held", err_flag, 1);
        end else begin
          pulse_clr();
          chk(err_flag == 1'b0, "R8 err cleared", err_flag, 0);
          chk(busy == 1'b1, a >= MAXT ? "R10 still repeating" : "R6 busy", busy, 1);
          tick();
          chk(io_drive_low == 1'b0, "R6 guard released", io_drive_low, 0);
          tick();
        end
      end else begin
        chk(tend_flag == 1'b1, "R7 tend set", tend_flag, 1);
        chk(err_flag == 1'b0, "R7 err stays clear", err_flag, 0);
        chk(busy == 1'b0, "R7 idle", busy, 0);
        chk(abort_flag == 1'b0, "R9 no abort", abort_flag, 0);
        chk(tend_irq == tend_ie, "R5 tend_irq", tend_irq, tend_ie);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(io_drive_low == 1'b0, "R1 line", io_drive_low, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk({err_flag, tend_flag, abort_flag} == 3'b000, "R1 flags",
        int'({err_flag, tend_flag, abort_flag}), 0);
    chk({err_irq, tend_irq} == 2'b00, "R1 irqs", int'({err_irq, tend_irq}), 0);
    tick();
    chk(io_drive_low == 1'b0, "R3 idle released", io_drive_low, 0);
    for (int v = 0; v < NV; v++)
      run_char(VEC[v][15:8], int'(VEC[v][7:4]), VEC[v][3], 1'b0);
    // interrupt masking
    err_ie = 1'b0; tend_ie = 1'b0;
    run_char(8'h33, 1, 1'b1, 1'b0);
    err_ie = 1'b1; tend_ie = 1'b1;
    // second start request during a frame
    run_char(8'h0F, 0, 1'b0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule